// File: doc/BRIEF.md
# CPU Exception Priority Sequencer

This block sits next to a processor core and decides which exception the core takes and when it takes it. At each instruction-end strobe it looks at the trace bit, the interrupt-control mode, a pending interrupt request, a trap-instruction strobe and the class of the instruction that just retired. It picks one exception by fixed priority and then runs a short handling sequence. Reset has the highest rank. It comes either from the synchronised reset pin being released or from a watchdog overflow pulse, and it preempts anything in progress.

For trace, interrupt and trap, the sequence asks the core to push the program counter and then the control word, each step waiting for an acknowledge. It then issues a mask/trace update for one cycle and requests a vector fetch at a computed vector index. Reset skips the two pushes. The NMI level that is sampled at reset release selects between a power-on reset and a manual reset. After reset handling, interrupts stay refused until the first instruction has retired.

Top module: `exc_prio_seq`

## Requirements
- R1: When several requests are eligible at one instruction end, trace wins over interrupt, and interrupt wins over trap.
- R2: From reset, and while the synchronised reset pin is low, `busy` is 1 and no step is requested. After the pin is seen high, the block issues one mask step and then one vector fetch. There are no pushes, the mask write carries all ones, and `trace_clr` is 1 in the mask step.
- R3: The NMI level sampled together with the pin release chooses the reset type. High gives vector 0 with `manual_rst`=0. Low gives vector 1 with `manual_rst`=1.
- R4: A watchdog overflow pulse, whether the block is idle or in the middle of a sequence, starts power-on reset handling: a mask step, then a fetch of vector 0.
- R5: After any reset handling completes, no interrupt is accepted at the first instruction end. A later instruction end does accept it.
- R6: Trace is eligible only when the mode input `icm` equals 2. Mode values 0, 1 and 3 never produce a trace.
- R7: Trace handling pulses `trace_clr`, asserts no `mask_wr`, and stacks a trace bit of 1.
- R8: No trace is taken at the end of a return-from-exception instruction (class code 2).
- R9: An interrupt is refused at the end of a control-word-writing instruction (class code 1) and at the end of a return-from-exception instruction (class code 2). Class code 0 is a plain instruction.
- R10: A trap strobe that arrives with an instruction end is never lost. If it loses arbitration, it is taken at the next instruction end.
- R11: Interrupt and trap handling steps are, in order: push PC (`step_kind` 0), push control word (`step_kind` 1), mask step, fetch (`step_kind` 2). Each requested step holds until `step_ack`.
- R12: Vector indices are 5 for trace, 8 plus the trap number for traps, and 16 plus the request number for interrupts. An interrupt writes its level into the mask. A trap writes all ones.
- R13: `busy` rises in the cycle after acceptance and falls only after the fetch is acknowledged. Instruction-end and trap strobes seen while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| res_n_pin | input | 1 | Reset pin, active low, synchronised inside |
| nmi_pin | input | 1 | NMI level, synchronised together with the reset pin |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_req | input | 1 | Interrupt request from the interrupt controller |
| irq_num | input | IRQ_W | Number of the requesting interrupt |
| irq_lvl | input | MASK_W | Mask level to install on interrupt acceptance |
| trap_strobe | input | 1 | Retiring instruction is a trap, qualified by `insn_end` |
| trap_num | input | TRAP_W | Trap number field |
| insn_end | input | 1 | Instruction-end strobe |
| insn_cls | input | 2 | Class of retiring instruction: 0 plain, 1 control-word write, 2 return-from-exception |
| trace_bit | input | 1 | Live trace bit of the control word |
| icm | input | ICM_W | Interrupt-control mode |
| step_ack | input | 1 | Acknowledge for the current push or fetch step |
| busy | output | 1 | Exception handling or reset hold in progress |
| step_req | output | 1 | A push or fetch step is requested |
| step_kind | output | 2 | 0 push PC, 1 push control word, 2 vector fetch, 3 none |
| stack_trace | output | 1 | Trace bit value to store with the stacked control word |
| mask_wr | output | 1 | Write `mask_val` into the interrupt mask |
| mask_val | output | MASK_W | New interrupt mask value |
| trace_clr | output | 1 | Clear the live trace bit (one cycle, the mask step) |
| vec_idx | output | VEC_W | Vector index, valid during the fetch step |
| manual_rst | output | 1 | Last reset was a manual reset |

## Verification
The hardest situation to reach is a trap that loses arbitration and must survive until a later instruction end. It has to coincide with a winning trace or interrupt whose full sequence runs in between. The bench sweeps every combination of mode, trace bit, instruction class, interrupt request and trap strobe. Whenever the trap was expected to lose, it completes the winning sequence, with varying acknowledge delays, and then issues a bare instruction end to collect the deferred trap. Watchdog overflow in the middle of a stalled push and strobes issued while busy are produced by holding back `step_ack` at chosen steps.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [1:0] {
      K_RESET = 2'd0,
      K_TRACE = 2'd1,
      K_IRQ   = 2'd2,
      K_TRAP  = 2'd3
   } exc_kind_t;

   typedef enum logic [1:0] {
      CLS_PLAIN    = 2'd0,
      CLS_CW_WRITE = 2'd1,
      CLS_RET_EXC  = 2'd2,
      CLS_RSVD     = 2'd3
   } insn_cls_t;

   typedef enum logic [1:0] {
      STP_PUSH_PC = 2'd0,
      STP_PUSH_CW = 2'd1,
      STP_FETCH   = 2'd2,
      STP_NONE    = 2'd3
   } step_t;

   typedef enum logic [2:0] {
      S_HOLD    = 3'd0,
      S_RUN     = 3'd1,
      S_PUSH_PC = 3'd2,
      S_PUSH_CW = 3'd3,
      S_MASK    = 3'd4,
      S_FETCH   = 3'd5
   } seq_state_t;

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("exc_sync: STAGES must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("exc_sync: W must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic [W-1:0] flop_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flop_q <= '0;
            else        flop_q <= d;
         end
         assign q = flop_q;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int IRQ_W         = 4,
   parameter int TRAP_W        = 2,
   parameter int MASK_W        = 3,
   parameter int ICM_W         = 2,
   parameter int VEC_W         = 8,
   parameter int TRACE_MODE    = 2,
   parameter int VEC_TRACE     = 5,
   parameter int VEC_TRAP_BASE = 8,
   parameter int VEC_IRQ_BASE  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arb_en,
   input  logic [1:0]        cls,
   input  logic              trace_bit,
   input  logic [ICM_W-1:0]  icm,
   input  logic              irq_req,
   input  logic [IRQ_W-1:0]  irq_num,
   input  logic [MASK_W-1:0] irq_lvl,
   input  logic              irq_blk,
   input  logic              trap_new,
   input  logic [TRAP_W-1:0] trap_num_new,
   input  logic              trap_pend,
   input  logic [TRAP_W-1:0] trap_num_pend,
   output logic              take,
   output exc_kind_t         kind,
   output logic [VEC_W-1:0]  vec,
   output logic [MASK_W-1:0] mask,
   output logic              use_pend
);

   localparam logic [ICM_W-1:0] TRACE_ICM = ICM_W'(TRACE_MODE);
   localparam logic [VEC_W-1:0] TRACE_VEC = VEC_W'(VEC_TRACE);
   localparam logic [VEC_W-1:0] TRAP_VEC0 = VEC_W'(VEC_TRAP_BASE);
   localparam logic [VEC_W-1:0] IRQ_VEC0  = VEC_W'(VEC_IRQ_BASE);

   insn_cls_t         cls_t;
   logic              trace_ok;
   logic              irq_ok;
   logic              trap_ok;
   logic [TRAP_W-1:0] trap_sel;

   assign cls_t    = insn_cls_t'(cls);
   assign trace_ok = trace_bit && (icm == TRACE_ICM) && (cls_t != CLS_RET_EXC);
   assign irq_ok   = irq_req && !irq_blk && (cls_t == CLS_PLAIN);
   assign trap_ok  = trap_pend || trap_new;
   assign trap_sel = trap_pend ? trap_num_pend : trap_num_new;
   assign take     = arb_en && (trace_ok || irq_ok || trap_ok);
   assign use_pend = trap_pend;

   always_comb begin
      kind = K_TRAP;
      vec  = TRAP_VEC0 + VEC_W'(trap_sel);
      mask = '1;
      if (trace_ok) begin
         kind = K_TRACE;
         vec  = TRACE_VEC;
         mask = '0;
      end else if (irq_ok) begin
         kind = K_IRQ;
         vec  = IRQ_VEC0 + VEC_W'(irq_num);
         mask = irq_lvl;
      end
   end

   // R6 / R8: trace only in the enabling mode and never after return-from-exception
   p_trace_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == K_TRACE) |-> (icm == TRACE_ICM && cls_t != CLS_RET_EXC));

   // R9 / R5: interrupt refused after control-word writes, returns and reset
   p_irq_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == K_IRQ) |-> (cls_t == CLS_PLAIN && !irq_blk));

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_pkg::*;
#(
   parameter int TRAP_W  = 2,
   parameter int MASK_W  = 3,
   parameter int VEC_W   = 8,
   parameter int VEC_POR = 0,
   parameter int VEC_MAN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_hi,
   input  logic              nmi_hi,
   input  logic              wdt_ovf,
   input  logic              insn_end,
   input  logic              trap_strobe,
   input  logic [TRAP_W-1:0] trap_num,
   input  logic              take,
   input  exc_kind_t         take_kind,
   input  logic [VEC_W-1:0]  take_vec,
   input  logic [MASK_W-1:0] take_mask,
   input  logic              take_used_pend,
   input  logic              trace_bit,
   input  logic              step_ack,
   output logic              arb_en,
   output logic              irq_blk,
   output logic              trap_pend,
   output logic [TRAP_W-1:0] trap_pend_num,
   output logic              busy,
   output logic              step_req,
   output logic [1:0]        step_kind,
   output logic              stack_trace,
   output logic              mask_wr,
   output logic [MASK_W-1:0] mask_val,
   output logic              trace_clr,
   output logic [VEC_W-1:0]  vec_idx,
   output logic              manual_rst
);

   localparam logic [VEC_W-1:0] POR_VEC = VEC_W'(VEC_POR);
   localparam logic [VEC_W-1:0] MAN_VEC = VEC_W'(VEC_MAN);

   seq_state_t        st;
   exc_kind_t         kind_q;
   logic [VEC_W-1:0]  vec_q;
   logic [MASK_W-1:0] mask_q;
   logic              stk_q;
   logic              man_q;
   logic              blk_q;
   logic              pend_q;
   logic [TRAP_W-1:0] pnum_q;
   logic              consume;
   step_t             step_t_v;

   assign consume = take && (take_kind == K_TRAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_HOLD;
         kind_q <= K_RESET;
         vec_q  <= '0;
         mask_q <= '0;
         stk_q  <= 1'b0;
         man_q  <= 1'b0;
         blk_q  <= 1'b1;
         pend_q <= 1'b0;
         pnum_q <= '0;
      end else if (!res_hi) begin
         st     <= S_HOLD;
         kind_q <= K_RESET;
         blk_q  <= 1'b1;
         pend_q <= 1'b0;
      end else if (wdt_ovf && st != S_HOLD) begin
         st     <= S_MASK;
         kind_q <= K_RESET;
         vec_q  <= POR_VEC;
         mask_q <= '1;
         stk_q  <= 1'b0;
         man_q  <= 1'b0;
         blk_q  <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         unique case (st)
            S_HOLD: begin
               st     <= S_MASK;
               kind_q <= K_RESET;
               man_q  <= !nmi_hi;
               vec_q  <= nmi_hi ? POR_VEC : MAN_VEC;
               mask_q <= '1;
               stk_q  <= 1'b0;
            end
            S_RUN: begin
               if (insn_end) begin
                  blk_q <= 1'b0;
                  if (consume) begin
                     if (take_used_pend && trap_strobe) begin
                        pend_q <= 1'b1;
                        pnum_q <= trap_num;
                     end else begin
                        pend_q <= 1'b0;
                     end
                  end else if (trap_strobe && !pend_q) begin
                     pend_q <= 1'b1;
                     pnum_q <= trap_num;
                  end
                  if (take) begin
                     st     <= S_PUSH_PC;
                     kind_q <= take_kind;
                     vec_q  <= take_vec;
                     mask_q <= take_mask;
                     stk_q  <= trace_bit;
                  end
               end
            end
            S_PUSH_PC: if (step_ack) st <= S_PUSH_CW;
            S_PUSH_CW: if (step_ack) st <= S_MASK;
            S_MASK:    st <= S_FETCH;
            S_FETCH:   if (step_ack) st <= S_RUN;
            default:   st <= S_HOLD;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         S_PUSH_PC: step_t_v = STP_PUSH_PC;
         S_PUSH_CW: step_t_v = STP_PUSH_CW;
         S_FETCH:   step_t_v = STP_FETCH;
         default:   step_t_v = STP_NONE;
      endcase
   end

   assign arb_en        = (st == S_RUN) && insn_end;
   assign irq_blk       = blk_q;
   assign trap_pend     = pend_q;
   assign trap_pend_num = pnum_q;
   assign busy          = (st != S_RUN);
   assign step_kind     = step_t_v;
   assign step_req      = (step_t_v != STP_NONE);
   assign stack_trace   = stk_q;
   assign trace_clr     = (st == S_MASK);
   assign mask_wr       = (st == S_MASK) && (kind_q != K_TRACE);
   assign mask_val      = mask_q;
   assign vec_idx       = vec_q;
   assign manual_rst    = man_q;

   // R11: control word is pushed only after the program counter
   p_push_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PUSH_CW) |-> ($past(st) == S_PUSH_PC || $past(st) == S_PUSH_CW));

   // R11: a requested step waits for its acknowledge
   p_step_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req && !step_ack && res_hi && !wdt_ovf) |=> (step_req && $stable(step_kind)));

   // R2 / R11: the mask step is followed by the vector fetch
   p_mask_then_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_MASK && res_hi && !wdt_ovf) |=> (st == S_FETCH));

   // R13: busy ends only on an acknowledged fetch
   p_busy_end_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(st == S_FETCH && step_ack));

   // R10: a trap strobe is either taken or kept pending
   p_trap_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN && insn_end && trap_strobe && res_hi && !wdt_ovf)
         |=> (pend_q || st == S_PUSH_PC));

endmodule

// File: rtl/exc_prio_seq.sv
module exc_prio_seq
   import exc_pkg::*;
#(
   parameter int IRQ_W         = 4,
   parameter int TRAP_W        = 2,
   parameter int MASK_W        = 3,
   parameter int ICM_W         = 2,
   parameter int VEC_W         = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int TRACE_MODE    = 2,
   parameter int VEC_POR       = 0,
   parameter int VEC_MAN       = 1,
   parameter int VEC_TRACE     = 5,
   parameter int VEC_TRAP_BASE = 8,
   parameter int VEC_IRQ_BASE  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_n_pin,
   input  logic              nmi_pin,
   input  logic              wdt_ovf,
   input  logic              irq_req,
   input  logic [IRQ_W-1:0]  irq_num,
   input  logic [MASK_W-1:0] irq_lvl,
   input  logic              trap_strobe,
   input  logic [TRAP_W-1:0] trap_num,
   input  logic              insn_end,
   input  logic [1:0]        insn_cls,
   input  logic              trace_bit,
   input  logic [ICM_W-1:0]  icm,
   input  logic              step_ack,
   output logic              busy,
   output logic              step_req,
   output logic [1:0]        step_kind,
   output logic              stack_trace,
   output logic              mask_wr,
   output logic [MASK_W-1:0] mask_val,
   output logic              trace_clr,
   output logic [VEC_W-1:0]  vec_idx,
   output logic              manual_rst
);

   localparam int VEC_SPAN  = 1 << VEC_W;
   localparam int TRAP_SPAN = 1 << TRAP_W;
   localparam int IRQ_SPAN  = 1 << IRQ_W;
   localparam int ICM_SPAN  = 1 << ICM_W;

   generate
      if (VEC_IRQ_BASE + IRQ_SPAN > VEC_SPAN) begin : g_bad_irq_range
         $error("exc_prio_seq: interrupt vectors exceed VEC_W");
      end
      if (VEC_TRAP_BASE + TRAP_SPAN > VEC_IRQ_BASE) begin : g_bad_trap_range
         $error("exc_prio_seq: trap vectors overlap interrupt vectors");
      end
      if (TRACE_MODE >= ICM_SPAN) begin : g_bad_mode
         $error("exc_prio_seq: TRACE_MODE does not fit ICM_W");
      end
      if (VEC_TRACE >= VEC_TRAP_BASE || VEC_POR == VEC_MAN) begin : g_bad_fixed_vec
         $error("exc_prio_seq: fixed vectors collide");
      end
   endgenerate

   logic [1:0]        sync_q;
   logic              arb_en;
   logic              irq_blk;
   logic              trap_pend;
   logic [TRAP_W-1:0] trap_pend_num;
   logic              take;
   exc_kind_t         take_kind;
   logic [VEC_W-1:0]  take_vec;
   logic [MASK_W-1:0] take_mask;
   logic              take_used_pend;

   exc_sync #(
      .STAGES (SYNC_STAGES),
      .W      (2)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({nmi_pin, res_n_pin}),
      .q     (sync_q)
   );

   exc_arbiter #(
      .IRQ_W         (IRQ_W),
      .TRAP_W        (TRAP_W),
      .MASK_W        (MASK_W),
      .ICM_W         (ICM_W),
      .VEC_W         (VEC_W),
      .TRACE_MODE    (TRACE_MODE),
      .VEC_TRACE     (VEC_TRACE),
      .VEC_TRAP_BASE (VEC_TRAP_BASE),
      .VEC_IRQ_BASE  (VEC_IRQ_BASE)
   ) u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .arb_en        (arb_en),
      .cls           (insn_cls),
      .trace_bit     (trace_bit),
      .icm           (icm),
      .irq_req       (irq_req),
      .irq_num       (irq_num),
      .irq_lvl       (irq_lvl),
      .irq_blk       (irq_blk),
      .trap_new      (trap_strobe),
      .trap_num_new  (trap_num),
      .trap_pend     (trap_pend),
      .trap_num_pend (trap_pend_num),
      .take          (take),
      .kind          (take_kind),
      .vec           (take_vec),
      .mask          (take_mask),
      .use_pend      (take_used_pend)
   );

   exc_seq #(
      .TRAP_W  (TRAP_W),
      .MASK_W  (MASK_W),
      .VEC_W   (VEC_W),
      .VEC_POR (VEC_POR),
      .VEC_MAN (VEC_MAN)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .res_hi         (sync_q[0]),
      .nmi_hi         (sync_q[1]),
      .wdt_ovf        (wdt_ovf),
      .insn_end       (insn_end),
      .trap_strobe    (trap_strobe),
      .trap_num       (trap_num),
      .take           (take),
      .take_kind      (take_kind),
      .take_vec       (take_vec),
      .take_mask      (take_mask),
      .take_used_pend (take_used_pend),
      .trace_bit      (trace_bit),
      .step_ack       (step_ack),
      .arb_en         (arb_en),
      .irq_blk        (irq_blk),
      .trap_pend      (trap_pend),
      .trap_pend_num  (trap_pend_num),
      .busy           (busy),
      .step_req       (step_req),
      .step_kind      (step_kind),
      .stack_trace    (stack_trace),
      .mask_wr        (mask_wr),
      .mask_val       (mask_val),
      .trace_clr      (trace_clr),
      .vec_idx        (vec_idx),
      .manual_rst     (manual_rst)
   );

endmodule

// File: tb/exc_prio_seq_tb.sv
`timescale 1ns/1ps
module exc_prio_seq_tb;

   localparam int IRQ_W  = 4;
   localparam int TRAP_W = 2;
   localparam int MASK_W = 3;
   localparam int ICM_W  = 2;
   localparam int VEC_W  = 8;
   localparam int FULL_CODE = 286;
   localparam int RST_CODE  = 30;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              res_n_pin = 1'b1;
   logic              nmi_pin = 1'b1;
   logic              wdt_ovf = 1'b0;
   logic              irq_req = 1'b0;
   logic [IRQ_W-1:0]  irq_num = '0;
   logic [MASK_W-1:0] irq_lvl = '0;
   logic              trap_strobe = 1'b0;
   logic [TRAP_W-1:0] trap_num = '0;
   logic              insn_end = 1'b0;
   logic [1:0]        insn_cls = 2'd0;
   logic              trace_bit = 1'b0;
   logic [ICM_W-1:0]  icm = '0;
   logic              step_ack = 1'b0;
   logic              busy;
   logic              step_req;
   logic [1:0]        step_kind;
   logic              stack_trace;
   logic              mask_wr;
   logic [MASK_W-1:0] mask_val;
   logic              trace_clr;
   logic [VEC_W-1:0]  vec_idx;
   logic              manual_rst;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   int s_code, s_len, g_vec, g_mw, g_mv, g_tc, g_stk, stall_bad;

   always #2 clk = ~clk;

   exc_prio_seq u_dut (
      .clk(clk), .rst_n(rst_n), .res_n_pin(res_n_pin), .nmi_pin(nmi_pin),
      .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_num(irq_num), .irq_lvl(irq_lvl),
      .trap_strobe(trap_strobe), .trap_num(trap_num), .insn_end(insn_end),
      .insn_cls(insn_cls), .trace_bit(trace_bit), .icm(icm), .step_ack(step_ack),
      .busy(busy), .step_req(step_req), .step_kind(step_kind),
      .stack_trace(stack_trace), .mask_wr(mask_wr), .mask_val(mask_val),
      .trace_clr(trace_clr), .vec_idx(vec_idx), .manual_rst(manual_rst)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Follows one handling sequence to its end; ack is withheld for hold cycles per step.
   task automatic run_seq(input int hold);
      s_code = 1; s_len = 0; g_vec = -1; g_mw = 0; g_mv = -1; g_tc = 0; g_stk = -1;
      stall_bad = 0;
      for (int it = 0; it < 80; it++) begin
         if (!busy) return;
         if (step_req) begin
            int k;
            k = int'(step_kind);
            s_code = s_code * 4 + k;
            s_len++;
            if (k == 2) g_vec = int'(vec_idx);
            if (k == 1) g_stk = int'(stack_trace);
            for (int h = 0; h < hold; h++) begin
               @(negedge clk);
               if (!step_req || int'(step_kind) != k) stall_bad++;
            end
            step_ack = 1'b1;
            @(negedge clk);
            step_ack = 1'b0;
         end else begin
            if (trace_clr) begin
               s_code = s_code * 4 + 3;
               s_len++;
               g_tc = 1;
               g_mw = int'(mask_wr);
               g_mv = int'(mask_val);
            end
            @(negedge clk);
         end
      end
      chk(1'b0, "R13 sequence never ended", int'(busy), 0);
   endtask

   task automatic issue(input int cls, input bit irq, input int inum, input int lvl,
                        input bit trap, input int tnum, input bit tb);
      insn_cls    = 2'(cls);
      irq_req     = irq;
      irq_num     = IRQ_W'(inum);
      irq_lvl     = MASK_W'(lvl);
      trap_strobe = trap;
      trap_num    = TRAP_W'(tnum);
      trace_bit   = tb;
      insn_end    = 1'b1;
      @(negedge clk);
      insn_end    = 1'b0;
      trap_strobe = 1'b0;
      irq_req     = 1'b0;
      trace_bit   = 1'b0;
      insn_cls    = 2'd0;
   endtask

   task automatic check_reset_seq(input string tag, input int exp_vec, input int exp_man);
      chk(s_code == RST_CODE && s_len == 2, {tag, " reset steps"}, s_code, RST_CODE);
      chk(g_vec == exp_vec, {tag, " reset vector"}, g_vec, exp_vec);
      chk(int'(manual_rst) == exp_man, {tag, " reset type"}, int'(manual_rst), exp_man);
      chk(g_mw == 1 && g_mv == 7 && g_tc == 1, "R2 reset mask all ones", g_mv, 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(busy == 1'b1, "R2 busy at reset", int'(busy), 1);
      chk(step_req == 1'b0, "R2 no step at reset", int'(step_req), 0);
      run_seq(0);
      check_reset_seq("R3", 0, 0);

      // R5: first instruction end after reset refuses an interrupt
      issue(0, 1'b1, 3, 2, 1'b0, 0, 1'b0);
      chk(busy == 1'b0, "R5 interrupt blocked after reset", int'(busy), 0);
      issue(0, 1'b1, 3, 2, 1'b0, 0, 1'b0);
      chk(busy == 1'b1, "R5 interrupt later accepted", int'(busy), 1);
      run_seq(1);
      chk(g_vec == 19, "R12 interrupt vector", g_vec, 19);

      // Sweep of every arbitration input combination
      begin
         int idx;
         idx = 0;
         for (int m = 0; m < 4; m++) begin
            for (int tb = 0; tb < 2; tb++) begin
               for (int c = 0; c < 3; c++) begin
                  for (int ir = 0; ir < 2; ir++) begin
                     for (int tp = 0; tp < 2; tp++) begin
                        int ek, inum, lvl, tnum, ev, emask;
                        inum = idx % 16;
                        lvl  = idx % 8;
                        tnum = idx % 4;
                        ek = 0;
                        if (tb == 1 && m == 2 && c != 2) ek = 1;
                        else if (ir == 1 && c == 0) ek = 2;
                        else if (tp == 1) ek = 3;
                        ev = (ek == 1) ? 5 : (ek == 2) ? 16 + inum : 8 + tnum;
                        emask = (ek == 2) ? lvl : 7;
                        icm = ICM_W'(m);
                        issue(c, ir[0], inum, lvl, tp[0], tnum, tb[0]);
                        chk(busy == (ek != 0), "R1 R6 R8 R9 accept decision",
                            int'(busy), int'(ek != 0));
                        if (ek != 0 && busy) begin
                           run_seq(idx % 3);
                           chk(s_code == FULL_CODE && s_len == 4, "R11 step order", s_code, FULL_CODE);
                           chk(stall_bad == 0, "R11 step held until ack", stall_bad, 0);
                           chk(g_vec == ev, "R1 R12 vector index", g_vec, ev);
                           chk(g_stk == tb, "R7 stacked trace bit", g_stk, tb);
                           if (ek == 1) begin
                              chk(g_mw == 0 && g_tc == 1, "R7 trace clears bit, no mask write", g_mw, 0);
                           end else begin
                              chk(g_mw == 1 && g_mv == emask, "R12 mask value", g_mv, emask);
                           end
                        end
                        if (tp == 1 && ek != 3) begin
                           issue(0, 1'b0, 0, 0, 1'b0, 0, 1'b0);
                           chk(busy == 1'b1, "R10 deferred trap taken", int'(busy), 1);
                           run_seq(0);
                           chk(g_vec == 8 + tnum, "R10 deferred trap vector", g_vec, 8 + tnum);
                        end
                        idx++;
                     end
                  end
               end
            end
         end
      end

      // R13: strobes while busy are ignored
      icm = 2'd0;
      issue(0, 1'b1, 5, 4, 1'b0, 0, 1'b0);
      chk(busy == 1'b1, "R13 busy after accept", int'(busy), 1);
      insn_end = 1'b1; trap_strobe = 1'b1; trap_num = 2'd2;
      @(negedge clk);
      insn_end = 1'b0; trap_strobe = 1'b0;
      run_seq(2);
      chk(g_vec == 21, "R13 sequence unaffected", g_vec, 21);
      issue(0, 1'b0, 0, 0, 1'b0, 0, 1'b0);
      chk(busy == 1'b0, "R13 busy-time trap ignored", int'(busy), 0);

      // R4: watchdog overflow mid-sequence
      issue(0, 1'b1, 2, 1, 1'b0, 0, 1'b0);
      chk(step_req == 1'b1 && step_kind == 2'd0, "R4 push pending", int'(step_kind), 0);
      wdt_ovf = 1'b1;
      @(negedge clk);
      wdt_ovf = 1'b0;
      run_seq(0);
      check_reset_seq("R4", 0, 0);
      issue(0, 1'b1, 2, 1, 1'b0, 0, 1'b0);
      chk(busy == 1'b0, "R5 interrupt blocked after watchdog", int'(busy), 0);

      // R4: watchdog overflow while idle
      wdt_ovf = 1'b1;
      @(negedge clk);
      wdt_ovf = 1'b0;
      chk(busy == 1'b1, "R4 idle watchdog starts reset", int'(busy), 1);
      run_seq(0);
      check_reset_seq("R4", 0, 0);

      // R2 / R3: pin held low, released with NMI low gives manual reset
      res_n_pin = 1'b0;
      nmi_pin = 1'b0;
      repeat (4) @(negedge clk);
      chk(busy == 1'b1 && step_req == 1'b0 && trace_clr == 1'b0, "R2 hold while pin low",
          int'(step_req), 0);
      res_n_pin = 1'b1;
      run_seq(1);
      check_reset_seq("R3", 1, 1);
      nmi_pin = 1'b1;
      res_n_pin = 1'b0;
      repeat (4) @(negedge clk);
      res_n_pin = 1'b1;
      run_seq(0);
      check_reset_seq("R3", 0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule